// File: doc/BRIEF.md
# Glitch-Safe Programmable Clock Divider

This block divides an input clock by a programmable integer ratio. A 32-bit setting word, written over a plain write strobe, carries a count of input cycles for the high phase and another for the low phase of the output. It also holds a bit that stretches the high phase to the next falling input edge, a bit that passes the input clock straight through, and a bit that stores the word without putting it into effect. One output period is the sum of the two counts. With ratio N, the low count is N/2 rounded up and the high count N/2 rounded down. The stretch bit is set only for odd N, which gives those ratios an even duty cycle.

A new setting never cuts an output period short. A write is held until the current period ends, and the next period starts with the new counts. A lock flag falls on the write that requests a change. It rises again only after the new setting has run for a fixed settling interval, so logic downstream knows when the divided clock can be trusted. The block has no data stream. The write port and the lock flag are plain control and status pins with no back-pressure.

Top module: `clkdiv_top`

## Requirements
- R1: After reset the stored word reads 0x0000_2000 (pass-through), `locked` is high and `clk_out` follows `clk_in`.
- R2: The word layout is: bits [5:0] low count, bits [11:6] high count, bit 12 stretch, bit 13 pass-through, bit 14 hold. A write stores bits [14:0], the stored word appears on `cfg_rdata` from the next cycle, and bits [31:15] of `cfg_rdata` always read 0.
- R3: With stretch clear, each output period rises on a rising input edge, stays high for the high count of input cycles, then stays low for the low count of input cycles.
- R4: With the pass-through bit set, `clk_out` equals `clk_in`.
- R5: With stretch set, the high phase lasts half an input cycle longer and ends on a falling input edge. The low phase is half a cycle shorter, and the period is unchanged.
- R6: A setting written mid-period takes effect only on the first rising input edge after the current output period completes. In pass-through mode that is the next rising input edge.
- R7: A write with bit 14 clear drops `locked` in the next cycle. `locked` stays low until 16 input cycles after the setting takes effect, then rises.
- R8: A write with bit 14 set only updates the stored word. `clk_out` and `locked` are unaffected until a later write with bit 14 clear applies the stored word.
- R9: With pass-through clear but a low or high count of 0, the block behaves as pass-through.
- R10: If several writes arrive before a period ends, the last word written is the one applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided; all state is clocked on its rising edge except the stretch flop |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the setting word |
| cfg_wdata | input | 32 | Setting word to store |
| cfg_rdata | output | 32 | Stored setting word, bits [31:15] zero |
| clk_out | output | 1 | Divided (or passed-through) clock |
| locked | output | 1 | High when the output runs stably at the current setting |

## Verification
The hardest case to reach is a change requested in the middle of a long output period, or several writes piled up before the boundary. The apply point, the lock drop and the settling interval then all happen at different times. The stimulus programs a 126-cycle period, lets it settle, and writes partway through it. It then issues two back-to-back writes inside an 80-cycle period and measures the period that follows. A behavioural model sampled at both clock phases follows every half cycle, so the stretch and pass-through transitions are checked at the exact edge they occur.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CNT_W     = 6;
  localparam int WORD_W    = 15;
  localparam int LO_LSB    = 0;
  localparam int HI_LSB    = 6;
  localparam int STRETCH_B = 12;
  localparam int PASS_B    = 13;
  localparam int HOLD_B    = 14;

  typedef struct packed {
    logic [CNT_W-1:0] lo;
    logic [CNT_W-1:0] hi;
    logic             stretch;
    logic             pass;
  } div_cfg_t;

  // Pass-through is forced when either phase count is zero (R9)
  function automatic div_cfg_t decode_word(input logic [WORD_W-1:0] w);
    div_cfg_t c;
    c.lo      = w[LO_LSB +: CNT_W];
    c.hi      = w[HI_LSB +: CNT_W];
    c.stretch = w[STRETCH_B];
    c.pass    = w[PASS_B] | (c.lo == '0) | (c.hi == '0);
    return c;
  endfunction
endpackage

// File: rtl/clkdiv_cfg_reg.sv
module clkdiv_cfg_reg
  import clkdiv_pkg::*;
#(
  parameter int                BUS_W      = 32,
  parameter logic [WORD_W-1:0] RESET_WORD = 15'h2000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             ack_i,
  output logic [BUS_W-1:0] rdata_o,
  output div_cfg_t         pend_o,
  output logic             req_o,
  output logic             commit_o
);
  localparam int PAD_W = BUS_W - WORD_W;

  logic [WORD_W-1:0] word_q;
  logic              req_q;
  logic              unused_hi;

  assign unused_hi = ^wdata_i[BUS_W-1:WORD_W];
  assign commit_o  = we_i & ~wdata_i[HOLD_B];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= RESET_WORD;
      req_q  <= 1'b0;
    end else begin
      if (we_i) word_q <= wdata_i[WORD_W-1:0];
      if (commit_o)   req_q <= 1'b1;
      else if (ack_i) req_q <= 1'b0;
    end
  end

  assign rdata_o = {{PAD_W{1'b0}}, word_q};
  assign pend_o  = decode_word(word_q);
  assign req_o   = req_q;
endmodule

// File: rtl/clkdiv_phase_gen.sv
module clkdiv_phase_gen
  import clkdiv_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_i,
  input  div_cfg_t pend_i,
  output logic     ack_o,
  output logic     div_o,
  output logic     stretch_o,
  output logic     pass_o
);
  localparam int PER_W = CNT_W + 1;

  div_cfg_t         act_q, act_n;
  logic [PER_W-1:0] cnt_q, cnt_n, last_pos;
  logic             div_q, div_n, boundary;

  assign last_pos = {1'b0, act_q.lo} + {1'b0, act_q.hi} - PER_W'(1);
  assign boundary = act_q.pass | (cnt_q == last_pos);
  assign ack_o    = boundary & req_i;

  always_comb begin
    act_n = act_q;
    if (boundary) begin
      if (ack_o) act_n = pend_i;
      cnt_n = '0;
      div_n = ~act_n.pass;
    end else begin
      cnt_n = cnt_q + PER_W'(1);
      div_n = (cnt_n < {1'b0, act_q.hi});
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '{lo: '0, hi: '0, stretch: 1'b0, pass: 1'b1};
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      act_q <= act_n;
      cnt_q <= cnt_n;
      div_q <= div_n;
    end
  end

  assign div_o     = div_q;
  assign stretch_o = act_q.stretch;
  assign pass_o    = act_q.pass;
endmodule

// File: rtl/clkdiv_lock_mon.sv
module clkdiv_lock_mon #(
  parameter int LOCK_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic commit_i,
  input  logic ack_i,
  output logic locked_o
);
  localparam int LC_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;

  logic [LC_W-1:0] lc_q;
  logic            run_q, locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lc_q     <= '0;
      run_q    <= 1'b0;
      locked_q <= 1'b1;
    end else if (commit_i) begin
      locked_q <= 1'b0;
      run_q    <= 1'b0;
    end else if (ack_i) begin
      locked_q <= 1'b0;
      run_q    <= 1'b1;
      lc_q     <= '0;
    end else if (run_q) begin
      if (lc_q == LC_W'(LOCK_CYCLES - 1)) begin
        locked_q <= 1'b1;
        run_q    <= 1'b0;
      end else begin
        lc_q <= lc_q + LC_W'(1);
      end
    end
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/clkdiv_edge_mux.sv
module clkdiv_edge_mux (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div_i,
  input  logic stretch_i,
  input  logic pass_i,
  output logic clk_o
);
  logic neg_q;

  // Falling-edge copy extends the high phase by half an input cycle
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= 1'b0;
    else         neg_q <= div_i;
  end

  assign clk_o = pass_i ? clk_i : (div_i | (stretch_i & neg_q));
endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
  import clkdiv_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int LOCK_CYCLES = 16
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [BUS_W-1:0] cfg_wdata,
  output logic [BUS_W-1:0] cfg_rdata,
  output logic             clk_out,
  output logic             locked
);
  div_cfg_t pend;
  logic     req, ack, commit, div_lvl, stretch, pass;

  clkdiv_cfg_reg #(.BUS_W(BUS_W)) u_cfg (
    .clk_i(clk_in), .rst_ni(rst_n), .we_i(cfg_we), .wdata_i(cfg_wdata),
    .ack_i(ack), .rdata_o(cfg_rdata), .pend_o(pend), .req_o(req),
    .commit_o(commit)
  );

  clkdiv_phase_gen u_phase (
    .clk_i(clk_in), .rst_ni(rst_n), .req_i(req), .pend_i(pend),
    .ack_o(ack), .div_o(div_lvl), .stretch_o(stretch), .pass_o(pass)
  );

  clkdiv_lock_mon #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk_i(clk_in), .rst_ni(rst_n), .commit_i(commit), .ack_i(ack),
    .locked_o(locked)
  );

  clkdiv_edge_mux u_mux (
    .clk_i(clk_in), .rst_ni(rst_n), .div_i(div_lvl), .stretch_i(stretch),
    .pass_i(pass), .clk_o(clk_out)
  );
endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker #(
  parameter int BUS_W       = 32,
  parameter int LOCK_CYCLES = 16
) (
  input logic             clk_in,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [BUS_W-1:0] cfg_wdata,
  input logic [BUS_W-1:0] cfg_rdata,
  input logic             locked
);
  localparam int RUN_W = $clog2(LOCK_CYCLES + 1) + 1;

  logic [RUN_W-1:0] low_run;
  logic             unused_top;

  assign unused_top = ^cfg_wdata[BUS_W-1:15];

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)                              low_run <= '0;
    else if (locked)                         low_run <= '0;
    else if (low_run < RUN_W'(LOCK_CYCLES))  low_run <= low_run + RUN_W'(1);
  end

  assert_rdata_pad_R2: assert property (@(posedge clk_in) disable iff (!rst_n)
    cfg_rdata[BUS_W-1:15] == '0);

  assert_readback_R2: assert property (@(posedge clk_in) disable iff (!rst_n)
    cfg_we |=> cfg_rdata[14:0] == $past(cfg_wdata[14:0]));

  assert_lock_drop_R7: assert property (@(posedge clk_in) disable iff (!rst_n)
    (cfg_we && !cfg_wdata[14]) |=> !locked);

  assert_lock_hold_R7: assert property (@(posedge clk_in) disable iff (!rst_n)
    $rose(locked) |-> low_run >= RUN_W'(LOCK_CYCLES));

  assert_hold_no_effect_R8: assert property (@(posedge clk_in) disable iff (!rst_n)
    (locked && cfg_we && cfg_wdata[14]) |=> locked);
endmodule

bind clkdiv_top clkdiv_checker #(.BUS_W(BUS_W), .LOCK_CYCLES(LOCK_CYCLES)) u_chk (
  .clk_in(clk_in), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .locked(locked)
);

// File: tb/clkdiv_top_tb.sv
`timescale 1ns/1ps
module clkdiv_top_tb;
  localparam int HALF = 4;   // 125 MHz

  logic        clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        clk_out, locked;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #HALF clk = ~clk;

  clkdiv_top u_dut (
    .clk_in(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .clk_out(clk_out), .locked(locked)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(int lo, int hi, int st, int ps, int hold);
    return 32'(lo) | (32'(hi) << 6) | (32'(st) << 12) | (32'(ps) << 13) | (32'(hold) << 14);
  endfunction

  // ---------------- reference model ----------------
  int m_word, m_req, m_lo, m_hi, m_st, m_ps, m_zero, m_pos, m_lvl, m_neg;
  int m_locked, m_run, m_lc, m_bnd, m_ack, m_commit;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_word = 32'h2000; m_req = 0; m_lo = 0; m_hi = 0; m_st = 0; m_ps = 1; m_zero = 0;
      m_pos = 0; m_lvl = 0; m_neg = 0; m_locked = 1; m_run = 0; m_lc = 0;
    end else begin
      m_bnd    = (m_ps != 0) || (m_pos == m_lo + m_hi - 1);
      m_ack    = m_bnd && m_req;
      m_commit = cfg_we && !cfg_wdata[14];
      m_neg    = m_lvl;
      if (m_bnd) begin
        if (m_ack) begin
          m_lo   = m_word & 63;
          m_hi   = (m_word >> 6) & 63;
          m_st   = (m_word >> 12) & 1;
          m_zero = (m_lo == 0 || m_hi == 0);
          m_ps   = (((m_word >> 13) & 1) != 0 || m_zero) ? 1 : 0;
        end
        m_pos = 0;
        m_lvl = (m_ps == 0);
      end else begin
        m_pos = m_pos + 1;
        m_lvl = (m_pos < m_hi);
      end
      if (m_commit) begin
        m_locked = 0; m_run = 0;
      end else if (m_ack) begin
        m_locked = 0; m_run = 1; m_lc = 0;
      end else if (m_run != 0) begin
        m_lc = m_lc + 1;
        if (m_lc == 16) begin m_locked = 1; m_run = 0; end
      end
      if (cfg_we) begin
        m_word = cfg_wdata & 32'h7fff;
        if (!cfg_wdata[14]) m_req = 1;
      end
      if (m_ack && !m_commit) m_req = 0;
    end
  end

  function automatic string clk_tag();
    if (m_req != 0) return "R6";
    if (m_ps != 0)  return (m_zero != 0) ? "R9" : "R4";
    if (m_st != 0)  return "R5";
    return "R3";
  endfunction

  always @(posedge clk) if (rst_n && !done) begin
    int e;
    #2;
    e = (m_ps != 0) ? 1 : ((m_lvl != 0) || (m_st != 0 && m_neg != 0));
    chk(clk_out == e, clk_tag(), clk_out, e);
    chk(locked == m_locked, "R7", locked, m_locked);
    chk(cfg_rdata == m_word, "R2", cfg_rdata, m_word);
  end

  always @(negedge clk) if (rst_n && !done) begin
    int e;
    #2;
    e = (m_ps != 0) ? 0 : m_lvl;
    chk(clk_out == e, clk_tag(), clk_out, e);
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wait_lock(output int n);
    n = 0;
    do begin @(posedge clk); #2; n++; end while (!locked && n < 2000);
  endtask

  task automatic measure(input int exp_per, input int exp_high2, input string req);
    realtime t0, t1, t2;
    @(posedge clk_out); t0 = $realtime;
    @(negedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    chk(int'((t2 - t0) / (2 * HALF)) == exp_per, req, int'((t2 - t0) / (2 * HALF)), exp_per);
    chk(int'((t1 - t0) / HALF) == exp_high2, req, int'((t1 - t0) / HALF), exp_high2);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(locked == 1'b1, "R1", locked, 1);
    chk(cfg_rdata == 32'h2000, "R1", cfg_rdata, 32'h2000);
    rst_n = 1'b1;
    @(posedge clk); #1; chk(clk_out == 1'b1, "R1", clk_out, 1);
    @(negedge clk); #1; chk(clk_out == 1'b0, "R1", clk_out, 0);

    wr(mk(2, 2, 0, 0, 0)); wait_lock(n);
    chk(n >= 16, "R7", n, 16);
    measure(4, 4, "R3");

    wr(mk(3, 2, 1, 0, 0)); wait_lock(n);
    measure(5, 5, "R5");                 // high 2.5 cycles = 5 half cycles

    wr(mk(3, 2, 0, 0, 0)); wait_lock(n);
    measure(5, 4, "R3");

    // R6: write in the middle of a 126-cycle period
    wr(mk(63, 63, 0, 0, 0)); wait_lock(n);
    repeat (40) @(negedge clk);
    wr(mk(1, 1, 0, 0, 0)); wait_lock(n);
    chk(n >= 16, "R7", n, 16);
    measure(2, 2, "R6");

    // R8: held write leaves output and lock alone
    wr(mk(1, 2, 0, 0, 1));
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); #2;
      chk(locked == 1'b1, "R8", locked, 1);
    end
    chk(cfg_rdata == mk(1, 2, 0, 0, 1), "R8", cfg_rdata, mk(1, 2, 0, 0, 1));
    measure(2, 2, "R8");
    wr(mk(2, 1, 0, 0, 0)); wait_lock(n);
    measure(3, 2, "R8");

    // R9: zero count falls back to pass-through
    wr(mk(0, 5, 0, 0, 0)); wait_lock(n);
    repeat (10) @(posedge clk);
    wr(mk(4, 0, 1, 0, 0)); wait_lock(n);
    repeat (10) @(posedge clk);

    // R4: explicit pass-through
    wr(mk(5, 5, 0, 1, 0)); wait_lock(n);
    repeat (10) @(posedge clk);

    // R10: back-to-back writes inside a long period
    wr(mk(40, 40, 0, 0, 0)); wait_lock(n);
    repeat (20) @(negedge clk);
    wr(mk(2, 2, 0, 0, 0));
    wr(mk(4, 3, 0, 0, 0)); wait_lock(n);
    measure(7, 6, "R10");

    // R2: upper bits discarded
    wr(32'hFFFF_8000 | mk(2, 3, 0, 0, 0));
    @(posedge clk); #2;
    chk(cfg_rdata == mk(2, 3, 0, 0, 0), "R2", cfg_rdata, mk(2, 3, 0, 0, 0));
    wait_lock(n);
    measure(5, 6, "R2");

    repeat (5) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(2 * HALF * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule